// File: doc/BRIEF.md
# CKE power-state tracker

This block follows the power state of a DDR3-style memory device. On each rising clock edge it looks at three things: the clock-enable level sampled now, the level that was sampled on the edge before, and the state the tracker held just before the edge. When the device is fully powered, it also uses a decoded command class and the device's activity at that moment. From these it picks one action. The device can enter active power-down, plain power-down, precharge power-down or self-refresh. It can leave either low-power state. It can stay where it is. Or the combination is illegal and gets flagged. A memory controller model or a protocol monitor can place it beside a DRAM interface to confirm that clock-enable sequencing is legal.

A second, independent check watches how long clock-enable stays at one level. After every change, the new level must be registered on a minimum number of consecutive edges, set by the parameter `MIN_HOLD`. A change that comes earlier raises a violation pulse. The reset input is asynchronous and active-low, and it is released through a short synchronizer. All outputs are registered, so they change on the same edge at which the inputs are sampled.

Top module: `cke_power_tracker`

## Requirements
- R1: After reset, `pstate_o` is 0 (fully powered) and every pulse output is low. The clock-enable level on the previous edge is taken as high, and the hold window is taken as already met.
- R2: In any low-power state (`pstate_o` 1 = active power-down, 2 = power-down, 3 = precharge power-down, 4 = self-refresh), clock-enable low on both the previous and present edges keeps the state with no pulse, whatever `cmd_i` is.
- R3: In a low-power state, clock-enable going low to high with `cmd_i` = 0 (deselect/NOP) returns `pstate_o` to 0. It pulses `sr_exit_o` when leaving state 4 and `pd_exit_o` when leaving states 1 to 3.
- R4: In a low-power state, clock-enable going low to high with any `cmd_i` other than 0 pulses `illegal_o` and leaves the state unchanged.
- R5: In state 0, clock-enable going high to low with `cmd_i` = 0 while `act_i` = 1 (banks open) enters state 1 and pulses `apd_entry_o`.
- R6: In state 0, clock-enable going high to low with `cmd_i` = 0 while `act_i` is 2 (reading), 3 (writing) or 4 (precharging) enters state 2 and pulses `pd_entry_o`.
- R7: In state 0, clock-enable going high to low with `cmd_i` = 0 enters state 3 and pulses `ppd_entry_o` in two cases: when `act_i` = 5 (refreshing), or when `act_i` = 0 (all banks idle) and `idle_ok_i` is high.
- R8: In state 0, clock-enable going high to low with `cmd_i` = 1 (REFRESH) while `act_i` = 0 and `idle_ok_i` is high enters state 4 and pulses `sr_entry_o`.
- R9: Any other high-to-low case in state 0 pulses `illegal_o` and keeps state 0. This covers an idle entry with `idle_ok_i` low, REFRESH while not idle, `cmd_i` of 2 or 3, and `act_i` of 6 or 7. Clock-enable low on the previous edge while in state 0 is also illegal.
- R10: In state 0, clock-enable high on both edges keeps state 0 with no pulse, whatever the command and activity.
- R11: If clock-enable changes before its current level has been registered on `MIN_HOLD` consecutive edges, `hold_viol_o` pulses on that edge. This happens regardless of the power state and of the other pulses.
- R12: Every pulse output is high for only the single cycle after the edge that caused it. At most one of the entry, exit and illegal pulses is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke_i | input | 1 | Clock-enable level registered at this edge |
| cmd_i | input | 2 | Command class: 0 deselect/NOP, 1 REFRESH, 2 or 3 other |
| act_i | input | 3 | Activity before the edge: 0 idle, 1 banks open, 2 read, 3 write, 4 precharge, 5 refresh |
| idle_ok_i | input | 1 | Idle qualifier: banks closed, no burst, prior timings met |
| pstate_o | output | 3 | Power state: 0 on, 1 active PD, 2 PD, 3 precharge PD, 4 self-refresh |
| apd_entry_o | output | 1 | Pulse: active power-down entered |
| pd_entry_o | output | 1 | Pulse: power-down entered |
| ppd_entry_o | output | 1 | Pulse: precharge power-down entered |
| sr_entry_o | output | 1 | Pulse: self-refresh entered |
| pd_exit_o | output | 1 | Pulse: any power-down left |
| sr_exit_o | output | 1 | Pulse: self-refresh left |
| illegal_o | output | 1 | Pulse: illegal state/clock-enable/command combination |
| hold_viol_o | output | 1 | Pulse: clock-enable changed inside its minimum hold window |

## Verification
The tracker stores only its power state, the last clock-enable level and a small hold counter, so any corruption shows up at the ports within one edge. A wrong state code appears on `pstate_o` directly. A wrong stored clock-enable level turns the next ordinary edge into an `illegal_o` pulse or a missing exit pulse. A counter that reloads or saturates wrongly produces a missing or spurious `hold_viol_o` when clock-enable next changes. The bench therefore walks each entry path and each exit path, checks every edge of every sequence, and places deliberate early changes on both the low and the high level.

// File: rtl/cke_pkg.sv
package cke_pkg;

  typedef enum logic [2:0] {
    PS_ON   = 3'd0,
    PS_APD  = 3'd1,
    PS_PD   = 3'd2,
    PS_PPD  = 3'd3,
    PS_SR   = 3'd4
  } pstate_t;

  localparam logic [1:0] CMD_NOP = 2'd0;
  localparam logic [1:0] CMD_REF = 2'd1;

  localparam logic [2:0] ACT_IDLE  = 3'd0;
  localparam logic [2:0] ACT_BANKS = 3'd1;
  localparam logic [2:0] ACT_READ  = 3'd2;
  localparam logic [2:0] ACT_WRITE = 3'd3;
  localparam logic [2:0] ACT_PRE   = 3'd4;
  localparam logic [2:0] ACT_RFSH  = 3'd5;

  typedef struct packed {
    logic apd_in;
    logic pd_in;
    logic ppd_in;
    logic sr_in;
    logic pd_out;
    logic sr_out;
    logic bad;
  } pulse_t;

endpackage

// File: rtl/cke_rst_sync.sv
module cke_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/cke_action_decode.sv
module cke_action_decode
  import cke_pkg::*;
(
  input  pstate_t    state_i,
  input  logic       cke_prev_i,
  input  logic       cke_i,
  input  logic [1:0] cmd_i,
  input  logic [2:0] act_i,
  input  logic       idle_ok_i,
  output pstate_t    next_o,
  output pulse_t     pulse_o
);
  always_comb begin
    next_o  = state_i;
    pulse_o = '0;
    if (state_i == PS_ON) begin
      if (cke_prev_i && !cke_i) begin
        if (cmd_i == CMD_NOP) begin
          case (act_i)
            ACT_BANKS: begin next_o = PS_APD; pulse_o.apd_in = 1'b1; end
            ACT_READ, ACT_WRITE, ACT_PRE:
                       begin next_o = PS_PD;  pulse_o.pd_in  = 1'b1; end
            ACT_RFSH:  begin next_o = PS_PPD; pulse_o.ppd_in = 1'b1; end
            ACT_IDLE: begin
              if (idle_ok_i) begin next_o = PS_PPD; pulse_o.ppd_in = 1'b1; end
              else pulse_o.bad = 1'b1;
            end
            default:   pulse_o.bad = 1'b1;
          endcase
        end else if (cmd_i == CMD_REF && act_i == ACT_IDLE && idle_ok_i) begin
          next_o = PS_SR;
          pulse_o.sr_in = 1'b1;
        end else begin
          pulse_o.bad = 1'b1;
        end
      end else if (!cke_prev_i) begin
        pulse_o.bad = 1'b1;
      end
    end else begin
      if (!cke_prev_i && cke_i && cmd_i == CMD_NOP) begin
        next_o = PS_ON;
        if (state_i == PS_SR) pulse_o.sr_out = 1'b1;
        else                  pulse_o.pd_out = 1'b1;
      end else if (cke_prev_i || cke_i) begin
        pulse_o.bad = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cke_hold_check.sv
module cke_hold_check #(
  parameter int MIN_HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_i,
  input  logic cke_prev_i,
  output logic viol_o
);
  localparam int CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_HOLD);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          change;

  always_comb begin
    change = (cke_i != cke_prev_i);
    viol_o = change && (cnt_q < FULL);
    if (change)            cnt_d = ONE;
    else if (cnt_q < FULL) cnt_d = cnt_q + ONE;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= FULL;
    else        cnt_q <= cnt_d;
  end

  // R11: counter never leaves its window
  p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= FULL));
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_pkg::*;
#(
  parameter int MIN_HOLD    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_i,
  input  logic [1:0] cmd_i,
  input  logic [2:0] act_i,
  input  logic       idle_ok_i,
  output logic [2:0] pstate_o,
  output logic       apd_entry_o,
  output logic       pd_entry_o,
  output logic       ppd_entry_o,
  output logic       sr_entry_o,
  output logic       pd_exit_o,
  output logic       sr_exit_o,
  output logic       illegal_o,
  output logic       hold_viol_o
);
  logic    rst_q_n;
  logic    cke_q;
  pstate_t st_q, st_d;
  pulse_t  pls_q, pls_d;
  logic    viol_q, viol_d;

  cke_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  cke_action_decode u_dec (
    .state_i(st_q), .cke_prev_i(cke_q), .cke_i(cke_i), .cmd_i(cmd_i),
    .act_i(act_i), .idle_ok_i(idle_ok_i), .next_o(st_d), .pulse_o(pls_d));

  cke_hold_check #(.MIN_HOLD(MIN_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_q_n), .cke_i(cke_i), .cke_prev_i(cke_q),
    .viol_o(viol_d));

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= PS_ON;
      cke_q  <= 1'b1;
      pls_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cke_q  <= cke_i;
      pls_q  <= pls_d;
      viol_q <= viol_d;
    end
  end

  assign pstate_o    = st_q;
  assign apd_entry_o = pls_q.apd_in;
  assign pd_entry_o  = pls_q.pd_in;
  assign ppd_entry_o = pls_q.ppd_in;
  assign sr_entry_o  = pls_q.sr_in;
  assign pd_exit_o   = pls_q.pd_out;
  assign sr_exit_o   = pls_q.sr_out;
  assign illegal_o   = pls_q.bad;
  assign hold_viol_o = viol_q;

  // R12: at most one action pulse per edge
  p_one_action_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({apd_entry_o, pd_entry_o, ppd_entry_o, sr_entry_o,
              pd_exit_o, sr_exit_o, illegal_o}));

  // R2: low on both edges in a low-power state keeps it quietly
  p_keep_low_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q != PS_ON && !cke_q && !cke_i) |=> ($stable(st_q) && !illegal_o));

  // R3: rising clock-enable with NOP leaves the low-power state
  p_exit_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q != PS_ON && !cke_q && cke_i && cmd_i == CMD_NOP)
      |=> (st_q == PS_ON && (pd_exit_o || sr_exit_o)));

  // R8: self-refresh is entered only from a qualified idle device
  p_sr_idle_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    sr_entry_o |-> (st_q == PS_SR && $past(act_i) == ACT_IDLE && $past(idle_ok_i)));

  // R9: an illegal edge leaves the state alone
  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    illegal_o |-> $stable(st_q));

  // R11: a violation only follows a clock-enable change
  p_viol_change_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    hold_viol_o |-> ($past(cke_i) != $past(cke_q)));
endmodule

// File: tb/cke_power_tracker_bench.sv
`timescale 1ns/1ps
module cke_power_tracker_bench;
  localparam logic [7:0] F_APD = 8'h80, F_PD = 8'h40, F_PPD = 8'h20, F_SR = 8'h10,
                         F_PDX = 8'h08, F_SRX = 8'h04, F_ILL = 8'h02, F_VIOL = 8'h01;
  localparam logic [1:0] NOP = 2'd0, REF = 2'd1, OTH = 2'd2;

  typedef struct {
    logic [2:0] st;
    logic [7:0] fl;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic [2:0] act = 3'd0;
  logic idle_ok = 1'b0;
  logic [2:0] pstate;
  logic apd, pd, ppd, sr, pdx, srx, ill, viol;
  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  cke_power_tracker u_cke_power_tracker (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cmd_i(cmd), .act_i(act),
    .idle_ok_i(idle_ok), .pstate_o(pstate), .apd_entry_o(apd), .pd_entry_o(pd),
    .ppd_entry_o(ppd), .sr_entry_o(sr), .pd_exit_o(pdx), .sr_exit_o(srx),
    .illegal_o(ill), .hold_viol_o(viol));

  function automatic logic [7:0] flags();
    return {apd, pd, ppd, sr, pdx, srx, ill, viol};
  endfunction

  task automatic compare(input string tag, input logic [2:0] st, input logic [7:0] fl);
    checks++;
    if (pstate !== st || flags() !== fl) begin
      errors++;
      $display("FAIL %s: state=%0d flags=%b expected state=%0d flags=%b",
               tag, pstate, flags(), st, fl);
    end
  endtask

  task automatic step(input logic c, input logic [1:0] cm, input logic [2:0] a,
                      input logic ok, input logic [2:0] st, input logic [7:0] fl,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cke = c; cmd = cm; act = a; idle_ok = ok;
    e.st = st; e.fl = fl; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (armed && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.tag, e.st, e.fl);
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset state", 3'd0, 8'h00);
    armed = 1'b1;
    // R10: high on both edges is quiet
    step(1, NOP, 3'd0, 1, 0, 8'h00, "R10 high-high nop");
    step(1, OTH, 3'd1, 0, 0, 8'h00, "R10 high-high other");
    // R5 active power-down, R2 stay, R3 exit
    step(0, NOP, 3'd1, 0, 1, F_APD, "R5 apd entry");
    step(0, OTH, 3'd1, 0, 1, 8'h00, "R2 stay other");
    step(0, REF, 3'd1, 0, 1, 8'h00, "R2 stay refresh");
    step(1, NOP, 3'd1, 0, 0, F_PDX, "R3 apd exit");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R12 pulse clears");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    // R6 reading
    step(0, NOP, 3'd2, 0, 2, F_PD, "R6 pd entry read");
    step(0, NOP, 3'd2, 0, 2, 8'h00, "R2 stay");
    step(0, NOP, 3'd2, 0, 2, 8'h00, "R2 stay");
    step(1, NOP, 3'd2, 0, 0, F_PDX, "R3 pd exit");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    // R6 writing, R4 bad exit, R11 early low
    step(0, NOP, 3'd3, 0, 2, F_PD, "R6 pd entry write");
    step(0, NOP, 3'd3, 0, 2, 8'h00, "R2 stay");
    step(0, NOP, 3'd3, 0, 2, 8'h00, "R2 stay");
    step(1, OTH, 3'd3, 0, 2, F_ILL, "R4 exit with other command");
    step(0, NOP, 3'd3, 0, 2, F_ILL | F_VIOL, "R11 early return low");
    step(0, NOP, 3'd3, 0, 2, 8'h00, "R2 stay");
    step(0, NOP, 3'd3, 0, 2, 8'h00, "R2 stay");
    step(1, NOP, 3'd3, 0, 0, F_PDX, "R3 pd exit");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    // R6 precharging
    step(0, NOP, 3'd4, 0, 2, F_PD, "R6 pd entry precharge");
    step(0, NOP, 3'd4, 0, 2, 8'h00, "R2 stay");
    step(0, NOP, 3'd4, 0, 2, 8'h00, "R2 stay");
    step(1, NOP, 3'd4, 0, 0, F_PDX, "R3 pd exit");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    // R7 refreshing and qualified idle
    step(0, NOP, 3'd5, 0, 3, F_PPD, "R7 ppd entry refreshing");
    step(0, NOP, 3'd5, 0, 3, 8'h00, "R2 stay");
    step(0, NOP, 3'd5, 0, 3, 8'h00, "R2 stay");
    step(1, NOP, 3'd5, 0, 0, F_PDX, "R3 ppd exit");
    step(1, NOP, 3'd0, 1, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd0, 1, 0, 8'h00, "R10 settle");
    step(0, NOP, 3'd0, 1, 3, F_PPD, "R7 ppd entry idle");
    step(0, NOP, 3'd0, 1, 3, 8'h00, "R2 stay");
    step(0, NOP, 3'd0, 1, 3, 8'h00, "R2 stay");
    step(1, NOP, 3'd0, 1, 0, F_PDX, "R3 ppd exit");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R10 settle");
    // R9 idle without qualifier, then low while on
    step(0, NOP, 3'd0, 0, 0, F_ILL, "R9 idle entry unqualified");
    step(0, NOP, 3'd0, 0, 0, F_ILL, "R9 low while on");
    step(0, NOP, 3'd0, 0, 0, F_ILL, "R9 low while on");
    step(1, NOP, 3'd0, 0, 0, F_ILL, "R9 rise while on");
    step(1, NOP, 3'd0, 1, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd0, 1, 0, 8'h00, "R10 settle");
    // R8 self-refresh
    step(0, REF, 3'd0, 1, 4, F_SR, "R8 sr entry");
    step(0, OTH, 3'd0, 1, 4, 8'h00, "R2 stay in sr");
    step(0, REF, 3'd0, 1, 4, 8'h00, "R2 stay in sr");
    step(1, NOP, 3'd0, 1, 0, F_SRX, "R3 sr exit");
    step(1, NOP, 3'd1, 0, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd1, 0, 0, 8'h00, "R10 settle");
    // R9 refresh while banks open
    step(0, REF, 3'd1, 0, 0, F_ILL, "R9 refresh not idle");
    step(0, NOP, 3'd1, 0, 0, F_ILL, "R9 low while on");
    step(0, NOP, 3'd1, 0, 0, F_ILL, "R9 low while on");
    step(1, NOP, 3'd1, 0, 0, F_ILL, "R9 rise while on");
    step(1, NOP, 3'd1, 0, 0, 8'h00, "R10 settle");
    step(1, NOP, 3'd1, 0, 0, 8'h00, "R10 settle");
    // R11 early rise on the high side
    step(0, NOP, 3'd1, 0, 1, F_APD, "R5 apd entry");
    step(1, NOP, 3'd1, 0, 0, F_PDX | F_VIOL, "R11 early exit");
    step(1, NOP, 3'd0, 0, 0, 8'h00, "R12 pulses clear");
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d results pending, expected 0", q.size());
    end
    finish_run();
  end
endmodule